// File: doc/BRIEF.md
# Command-Driven 16-Bit Down-Counting Timer

This block is a programmable down-counter with a byte-wide register port. Two byte registers hold the reload value, low byte and high byte. A third location accepts one-shot command codes that change the timer's modes or run state. The command does its work in the cycle it is written and is not stored. A read of that same location does not return the last command. It returns the interrupt status, and the read acknowledges the pending event.

The counter counts ticks of one of two sources. The first is an internal clock-enable input. The second is an external clock pin, which passes through a synchroniser and a rising-edge detector. A tick that finds the count at zero is a terminal event. The terminal event sets a pending flag. In re-triggerable mode the count then reloads and continues. In one-shot mode the timer halts. The interrupt line shows the pending flag gated by the interrupt enable. When routing is on, a one-cycle pulse at each terminal event appears on the timer output pin.

Top module: `cmd_timer`

## Requirements
- R1: After reset, both byte registers and the control location read 0x00, irq is low and tmr_out is low. Reset leaves the timer stopped, the interrupt disabled, re-triggerable mode, internal source and the output unrouted.
- R2: A write to address 0 stores the low byte of the reload value and a write to address 1 stores the high byte. Reading either address returns the stored byte, and neither register changes without a write to it.
- R3: The start command (code 9) loads the counter from the reload value N. Each later tick decrements the count. The tick that finds the count at zero sets the pending flag, so the first terminal event falls on tick N+1 after the start.
- R4: A read of address 2 returns 0x01 when the interrupt is enabled and an event is pending, and 0x00 otherwise. The read clears the pending flag. A terminal event in the same cycle as the read is kept.
- R5: Code 1 enables and code 2 disables the interrupt. irq is high exactly when an event is pending and the interrupt is enabled. Disabling the interrupt does not discard a pending event.
- R6: In re-triggerable mode (code 4, the reset default), a terminal event reloads N and counting continues, so events recur every N+1 ticks.
- R7: In one-shot mode (code 3), a terminal event halts the timer until the next start command.
- R8: The stop command (code 10) freezes the count, and ticks have no effect while the timer is stopped. A later start reloads N.
- R9: Code 5 selects the tick_int input as the tick source. Code 6 selects ext_clk, where each rising edge is one tick after a two-flop synchroniser and an edge detector. While ext_clk is selected, tick_int is ignored.
- R10: Code 7 routes the output. While routed, tmr_out is high for the one cycle that follows each terminal event. Code 8 unroutes it, and tmr_out then stays low.
- R11: The reset-timer command (code 11) restores all R1 modes, stops the timer and clears the pending flag. It leaves both reload bytes unchanged.
- R12: Only bits 3:0 of a control write form the command, and bits 7:4 are ignored. Codes 0 and 12 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; clears pending on a control read |
| addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed location |
| tick_int | input | 1 | Internal count enable, one tick per high cycle |
| ext_clk | input | 1 | External count clock, asynchronous |
| irq | output | 1 | Interrupt: pending and enabled |
| tmr_out | output | 1 | Terminal-count pulse when routed |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that ext_clk stays at each level for at least two clock periods, so the synchroniser sees every edge. The bench issues each register access alone, with idle cycles between accesses. It holds ext_clk high for two cycles and low for two cycles. It keeps tick_int low during register accesses, so every tick it counts falls in a measurement window whose expected length it works out as N+1.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

  localparam logic [3:0] CMD_NOP       = 4'd0;
  localparam logic [3:0] CMD_IRQ_ON    = 4'd1;
  localparam logic [3:0] CMD_IRQ_OFF   = 4'd2;
  localparam logic [3:0] CMD_ONESHOT   = 4'd3;
  localparam logic [3:0] CMD_RETRIG    = 4'd4;
  localparam logic [3:0] CMD_SRC_INT   = 4'd5;
  localparam logic [3:0] CMD_SRC_EXT   = 4'd6;
  localparam logic [3:0] CMD_ROUTE     = 4'd7;
  localparam logic [3:0] CMD_UNROUTE   = 4'd8;
  localparam logic [3:0] CMD_START     = 4'd9;
  localparam logic [3:0] CMD_STOP      = 4'd10;
  localparam logic [3:0] CMD_RESET     = 4'd11;

  typedef struct packed {
    logic irq_en;
    logic one_shot;
    logic ext_src;
    logic routed;
  } tmr_mode_t;

  localparam tmr_mode_t MODE_DEFAULT = '{irq_en: 1'b0, one_shot: 1'b0,
                                         ext_src: 1'b0, routed: 1'b0};

endpackage

// File: rtl/tmr_bus_regs.sv
`timescale 1ns/1ps
module tmr_bus_regs #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              status_bit,
  output logic [CNT_W-1:0]  load_val,
  output logic [7:0]        rdata,
  output logic              cmd_vld,
  output logic [3:0]        cmd_code,
  output logic              status_rd
);

  localparam int                NBYTES    = CNT_W / 8;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NBYTES);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [7:0] byte_q;
    logic       byte_we;
    assign byte_we = wr_en && (addr == ADDR_W'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= '0;
      else if (byte_we) byte_q <= wdata;
    end
    assign load_val[b*8 +: 8] = byte_q;
  end

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (addr == ADDR_W'(b)) rdata = load_val[b*8 +: 8];
    end
    if (addr == CTRL_ADDR) rdata = {7'b0, status_bit};
  end

  assign cmd_vld   = wr_en && (addr == CTRL_ADDR);
  assign cmd_code  = wdata[3:0];
  assign status_rd = rd_en && (addr == CTRL_ADDR);

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_en)); // R2
  AST_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(load_val)); // R2

endmodule

// File: rtl/tmr_cmd_dec.sv
`timescale 1ns/1ps
module tmr_cmd_dec
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_vld,
  input  logic [3:0] cmd_code,
  output tmr_mode_t mode,
  output logic      start_p,
  output logic      stop_p,
  output logic      reset_p
);

  tmr_mode_t mode_q, mode_d;

  always_comb begin
    mode_d  = mode_q;
    start_p = 1'b0;
    stop_p  = 1'b0;
    reset_p = 1'b0;
    if (cmd_vld) begin
      case (cmd_code)
        CMD_IRQ_ON:  mode_d.irq_en   = 1'b1;
        CMD_IRQ_OFF: mode_d.irq_en   = 1'b0;
        CMD_ONESHOT: mode_d.one_shot = 1'b1;
        CMD_RETRIG:  mode_d.one_shot = 1'b0;
        CMD_SRC_INT: mode_d.ext_src  = 1'b0;
        CMD_SRC_EXT: mode_d.ext_src  = 1'b1;
        CMD_ROUTE:   mode_d.routed   = 1'b1;
        CMD_UNROUTE: mode_d.routed   = 1'b0;
        CMD_START:   start_p         = 1'b1;
        CMD_STOP:    stop_p          = 1'b1;
        CMD_RESET: begin
          mode_d  = MODE_DEFAULT;
          reset_p = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_DEFAULT;
    else        mode_q <= mode_d;
  end

  assign mode = mode_q;

  AST_RSV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && ((cmd_code == CMD_NOP) || (cmd_code >= 4'd12))) |=> $stable(mode_q)); // R12
  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && (cmd_code == CMD_RESET)) |=> (mode_q == MODE_DEFAULT)); // R11

endmodule

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_p
);

  logic [SYNC_STAGES:0] sh_q, sh_d;

  assign sh_d = {sh_q[SYNC_STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_p = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |=> !rise_p); // R9

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  input  logic             one_shot,
  input  logic             start_p,
  input  logic             stop_p,
  input  logic             reset_p,
  input  logic             status_rd,
  output logic             pending,
  output logic             tc_pulse
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             pend_q, pend_d;
  logic             tcp_q;
  logic             tc_event;

  always_comb begin
    cnt_d    = cnt_q;
    run_d    = run_q;
    pend_d   = pend_q;
    tc_event = 1'b0;
    if (status_rd) pend_d = 1'b0;
    if (reset_p) begin
      cnt_d  = '0;
      run_d  = 1'b0;
      pend_d = 1'b0;
    end else if (start_p) begin
      cnt_d = load_val;
      run_d = 1'b1;
    end else if (stop_p) begin
      run_d = 1'b0;
    end else if (run_q && tick) begin
      if (cnt_q == '0) begin
        tc_event = 1'b1;
        pend_d   = 1'b1;
        if (one_shot) run_d = 1'b0;
        else          cnt_d = load_val;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      tcp_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      pend_q <= pend_d;
      tcp_q  <= tc_event;
    end
  end

  assign pending  = pend_q;
  assign tc_pulse = tcp_q;

  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && (cnt_q != '0) && !start_p && !stop_p && !reset_p)
      |=> (cnt_q == $past(cnt_q) - ONE)); // R3
  AST_TC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    tcp_q |-> pend_q); // R3
  AST_RETRIG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_event && !one_shot) |=> (run_q && (cnt_q == $past(load_val)))); // R6
  AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_event && one_shot) |=> !run_q); // R7
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_p && !reset_p) |=> $stable(cnt_q)); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !tc_event) |=> !pend_q); // R4

endmodule

// File: rtl/cmd_timer.sv
`timescale 1ns/1ps
module cmd_timer
  import tmr_pkg::*;
#(
  parameter  int CNT_W       = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int ADDR_W      = $clog2(CNT_W / 8 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              tick_int,
  input  logic              ext_clk,
  output logic              irq,
  output logic              tmr_out
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CNT_W / 8);

  logic [1:0]       rst_pipe_q;
  logic             rst_s_n;
  logic [CNT_W-1:0] load_val;
  logic             cmd_vld;
  logic [3:0]       cmd_code;
  logic             status_rd;
  tmr_mode_t        mode;
  logic             start_p, stop_p, reset_p;
  logic             ext_rise;
  logic             tick;
  logic             pending;
  logic             tc_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  tmr_bus_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .status_bit (irq),
    .load_val   (load_val),
    .rdata      (rdata),
    .cmd_vld    (cmd_vld),
    .cmd_code   (cmd_code),
    .status_rd  (status_rd)
  );

  tmr_cmd_dec u_dec (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .cmd_vld  (cmd_vld),
    .cmd_code (cmd_code),
    .mode     (mode),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .reset_p  (reset_p)
  );

  tmr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .async_in (ext_clk),
    .rise_p   (ext_rise)
  );

  assign tick = mode.ext_src ? ext_rise : tick_int;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tick      (tick),
    .load_val  (load_val),
    .one_shot  (mode.one_shot),
    .start_p   (start_p),
    .stop_p    (stop_p),
    .reset_p   (reset_p),
    .status_rd (status_rd),
    .pending   (pending),
    .tc_pulse  (tc_pulse)
  );

  assign irq     = pending & mode.irq_en;
  assign tmr_out = tc_pulse & mode.routed;

  AST_STATUS_IRQ: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rd_en && (addr == CTRL_ADDR)) |-> (rdata == {7'b0, irq})); // R4
  AST_OUT_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_s_n)
    tmr_out |-> $past(tick)); // R10
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_vld && (cmd_code == CMD_IRQ_OFF)) |=> !irq); // R5

endmodule

// File: tb/tb_cmd_timer.sv
`timescale 1ns/1ps
module tb_cmd_timer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       tick_int = 1'b0;
  logic       ext_clk = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  logic       tmr_out;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_int(tick_int), .ext_clk(ext_clk),
    .irq(irq), .tmr_out(tmr_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c);
    wr(2'd2, c);
  endtask

  task automatic load(input int n);
    wr(2'd0, n[7:0]);
    wr(2'd1, n[15:8]);
  endtask

  // Tick every 'period' cycles until irq rises or 'limit' cycles pass.
  task automatic run_ticks(input int period, input int limit, output int ticks, output bit hit);
    ticks = 0;
    hit = 1'b0;
    for (int i = 0; i < limit && !hit; i++) begin
      tick_int = ((i % period) == 0);
      @(negedge clk);
      if (tick_int) ticks++;
      hit = irq;
    end
    tick_int = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int         t;
    bit         h;
    int         nlist [10] = '{0, 1, 2, 3, 4, 7, 16, 255, 256, 1000};
    int         bad;
    int         rises;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(2'd0, d); check("R1 low byte", d, 0);
    rd(2'd1, d); check("R1 high byte", d, 0);
    rd(2'd2, d); check("R1 control", d, 0);
    check("R1 irq", irq, 0);
    check("R1 tmr_out", tmr_out, 0);

    // R2: byte registers
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
    rd(2'd0, d); check("R2 low byte", d, 8'hA5);
    rd(2'd1, d); check("R2 high byte", d, 8'h3C);

    // R3/R4 sweep: reload values and tick spacings
    cmd(8'h01);
    foreach (nlist[k]) begin
      for (int p = 1; p <= 3; p += 2) begin
        load(nlist[k]);
        cmd(8'h09);
        run_ticks(p, 4000, t, h);
        check($sformatf("R3 n=%0d p=%0d ticks", nlist[k], p), t, nlist[k] + 1);
        rd(2'd2, d);
        check("R4 status read", d, 1);
        check("R4 read clears", irq, 0);
        cmd(8'h0A);
      end
    end

    // R5: disable keeps pending
    load(2); cmd(8'h09);
    run_ticks(1, 20, t, h);
    cmd(8'h0A);
    cmd(8'h02);
    check("R5 irq off", irq, 0);
    cmd(8'h01);
    check("R5 irq back", irq, 1);
    rd(2'd2, d); check("R5 status", d, 1);
    check("R5 cleared", irq, 0);

    // R6: re-triggerable reload
    cmd(8'h04); load(4); cmd(8'h09);
    run_ticks(1, 50, t, h); check("R6 first period", t, 5);
    rd(2'd2, d);
    run_ticks(1, 50, t, h); check("R6 second period", t, 5);
    rd(2'd2, d);
    cmd(8'h0A);

    // R7: one-shot halt
    cmd(8'h03); load(3); cmd(8'h09);
    run_ticks(1, 50, t, h); check("R7 first", t, 4);
    rd(2'd2, d);
    run_ticks(1, 30, t, h); check("R7 halted", h, 0);
    cmd(8'h09);
    run_ticks(1, 50, t, h); check("R7 restart", t, 4);
    rd(2'd2, d);
    cmd(8'h04);

    // R8: stop freezes, start reloads
    load(5); cmd(8'h09);
    run_ticks(1, 3, t, h); check("R8 partial", h, 0);
    cmd(8'h0A);
    run_ticks(1, 20, t, h); check("R8 stopped", h, 0);
    cmd(8'h09);
    run_ticks(1, 50, t, h); check("R8 reload", t, 6);
    rd(2'd2, d);
    cmd(8'h0A);

    // R9: external clock source, tick_int ignored
    cmd(8'h06); load(2); cmd(8'h09);
    rises = 0; h = 1'b0;
    for (int i = 0; i < 200 && !h; i++) begin
      ext_clk = ((i % 4) < 2);
      tick_int = 1'b1;
      if ((i % 4) == 0) rises++;
      @(negedge clk);
      h = irq;
    end
    tick_int = 1'b0; ext_clk = 1'b0;
    check("R9 ext hit", h, 1);
    check("R9 ext rises", rises, 3);
    cmd(8'h0A);
    cmd(8'h05);
    rd(2'd2, d);
    load(1); cmd(8'h09);
    run_ticks(1, 20, t, h); check("R9 internal again", t, 2);
    rd(2'd2, d);
    cmd(8'h0A);

    // R10: routed pulse, then unrouted
    cmd(8'h07); load(2); cmd(8'h09);
    bad = 0;
    for (int i = 0; i < 9; i++) begin
      tick_int = 1'b1;
      @(negedge clk);
      if (tmr_out != ((i % 3) == 2)) bad++;
    end
    tick_int = 1'b0;
    check("R10 routed pulses", bad, 0);
    cmd(8'h0A); cmd(8'h08); cmd(8'h09);
    bad = 0;
    for (int i = 0; i < 9; i++) begin
      tick_int = 1'b1;
      @(negedge clk);
      if (tmr_out) bad++;
    end
    tick_int = 1'b0;
    check("R10 unrouted low", bad, 0);
    cmd(8'h0A);
    rd(2'd2, d);

    // R11: reset-timer command
    cmd(8'h01); cmd(8'h03); cmd(8'h06); cmd(8'h07);
    load(1); cmd(8'h09);
    cmd(8'h0B);
    check("R11 irq", irq, 0);
    rd(2'd2, d); check("R11 status", d, 0);
    rd(2'd0, d); check("R11 low kept", d, 1);
    rd(2'd1, d); check("R11 high kept", d, 0);
    cmd(8'h09);
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      tick_int = 1'b1;
      @(negedge clk);
      if (tmr_out || irq) bad++;
    end
    tick_int = 1'b0;
    check("R11 unrouted and disabled", bad, 0);
    cmd(8'h01);
    check("R11 pending on internal", irq, 1);
    rd(2'd2, d);
    run_ticks(1, 10, t, h); check("R11 retrig default", t, 2);
    cmd(8'h0A);
    rd(2'd2, d);

    // R12: reserved codes and upper bits
    cmd(8'h00); cmd(8'h0C); cmd(8'h0D); cmd(8'h0E); cmd(8'h0F); cmd(8'hF0); cmd(8'h5C);
    run_ticks(1, 10, t, h); check("R12 no start", h, 0);
    rd(2'd2, d); check("R12 status", d, 0);
    cmd(8'hF9);
    run_ticks(1, 10, t, h); check("R12 upper nibble ignored", t, 2);
    check("R12 routing unchanged", tmr_out, 0);
    rd(2'd2, d); check("R12 irq still enabled", d, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule